// File: doc/BRIEF.md
# Completion Status Queue with Self-Queued MSI

This block sits beside a pair of DMA data movers, one that reads from host memory and one that writes to it. Each mover hands back a completion status word per descriptor. Two control bits inside each word decide what happens to it. The block either discards the word or stores it in a per-mover status FIFO, and it may also raise an interrupt. Software drains the FIFOs through a small register port. A read of an empty FIFO returns a marker instead of data.

The block does not drive a dedicated interrupt wire. It builds an immediate-write descriptor that writes a programmed MSI data word to a programmed MSI address. It then places that descriptor into the write mover's normal or priority descriptor queue, as the mover's interrupt control register selects. These descriptors share both queues with host descriptor pushes. An MSI always wins a same-queue conflict, and the host push is held with a wait signal.

Top module: `sqm_status_msi`

## Requirements
- R1: A status word whose control bits [13:12] are 00 is discarded. It is not stored in the status FIFO and raises no MSI.
- R2: A status word with control bits 01, 10 or 11 is stored in its mover's FIFO, and the words are kept in arrival order. A read of a non-empty FIFO (CSR address 0 for the write mover, 1 for the read mover) returns the oldest word in bits [30:0] with bit 31 clear, and then removes that word.
- R3: A read of an empty status FIFO returns 0x8000_0000, that is bit 31 set and every other bit zero. The read leaves the FIFO unchanged.
- R4: An MSI is requested for control bits 11 in every case, and for 10 only when error bit 15 of the status word is set. Control bits 01 and 00 never request one.
- R5: A requested MSI produces a descriptor only when the enable bit (flags bit 0) of that mover's interrupt control register is set.
- R6: An MSI descriptor (112 bits) has the MSI data in [31:0], the 64-bit MSI address in [95:32], a transfer size of 1 word in [108:96], the immediate bit [109] set, and its own control bits [111:110] at 00. Every other bit is zero. Host descriptors pass to the queues unchanged.
- R7: Flags bit 1 of the requesting mover's control register selects the target queue: 1 gives the priority queue and 0 gives the normal queue.
- R8: When a host push and an MSI target the same queue in the same cycle, the MSI is offered and host_wait is high until the MSI has been taken.
- R9: A pending MSI stays offered while its target queue is not ready. Status words that arrive during that time are still accepted and stored in order.
- R10: A host push goes to the queue chosen by host_prio, and host_wait follows that queue's not-ready while no MSI competes for it. With no push and no pending MSI, neither queue valid is asserted.
- R11: When both movers have an MSI pending, the write mover's MSI is issued first.
- R12: Each mover has four readable and writable control words at CSR addresses 2+4m+k, with m=0 for the write mover and m=1 for the read mover. k=0 holds the flags (bit 0 enable, bit 1 priority), k=1 the address low word, k=2 the address high word and k=3 the MSI data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sts_valid | input | 1 | Write mover status word valid |
| wr_sts_ready | output | 1 | Write mover status word accepted |
| wr_sts_word | input | 31 | Write mover status word |
| rd_sts_valid | input | 1 | Read mover status word valid |
| rd_sts_ready | output | 1 | Read mover status word accepted |
| rd_sts_word | input | 31 | Read mover status word |
| csr_addr | input | 4 | Register port word address |
| csr_write | input | 1 | Register write strobe |
| csr_read | input | 1 | Register read strobe (pops a status FIFO) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational |
| host_push | input | 1 | Host descriptor push request |
| host_prio | input | 1 | Host push targets the priority queue |
| host_desc | input | 112 | Host descriptor |
| host_wait | output | 1 | Host push not taken this cycle |
| wq_norm_valid | output | 1 | Normal write-mover queue descriptor valid |
| wq_norm_ready | input | 1 | Normal write-mover queue ready |
| wq_norm_desc | output | 112 | Normal write-mover queue descriptor |
| wq_prio_valid | output | 1 | Priority write-mover queue descriptor valid |
| wq_prio_ready | input | 1 | Priority write-mover queue ready |
| wq_prio_desc | output | 112 | Priority write-mover queue descriptor |

## Verification
Status words are driven with all four control codes and with the error bit both set and clear. This separates the drop, keep-only and interrupt outcomes, and shows that code 10 depends on the error flag alone. The interrupt enable and queue-select bits are flipped between runs to show that they gate and steer the descriptor independently. Backpressure is applied on the normal queue while MSIs are pending and a host push waits, which tests MSI-first ordering and in-order status capture. Simultaneous interrupts from both movers test the fixed mover order.

// File: rtl/sqm_pkg.sv
`timescale 1ns/1ps
package sqm_pkg;
  localparam int MOVERS   = 2;
  localparam int STS_W    = 31;
  localparam int DESC_W   = 112;
  localparam int CTL_LO   = 12;
  localparam int ERR_BIT  = 15;
  localparam int F_DATA   = 0;
  localparam int F_ADDR   = 32;
  localparam int F_SIZE   = 96;
  localparam int SIZE_W   = 13;
  localparam int F_IMM    = 109;
  localparam int F_ACTL   = 110;
  localparam logic [31:0] EMPTY_WORD = 32'h8000_0000;

  typedef struct packed {
    logic        en;
    logic        prio;
    logic [63:0] addr;
    logic [31:0] data;
  } irq_ctl_t;

  function automatic logic sts_keep(input logic [1:0] ctl);
    return ctl != 2'b00;
  endfunction

  function automatic logic sts_irq(input logic [1:0] ctl, input logic err);
    return (ctl == 2'b11) || (ctl == 2'b10 && err);
  endfunction

  function automatic logic [DESC_W-1:0] msi_desc(input logic [63:0] a, input logic [31:0] d);
    logic [DESC_W-1:0] r;
    r = '0;
    r[F_DATA +: 32]     = d;
    r[F_ADDR +: 64]     = a;
    r[F_SIZE +: SIZE_W] = SIZE_W'(1);
    r[F_IMM]            = 1'b1;
    r[F_ACTL +: 2]      = 2'b00;
    return r;
  endfunction

  function automatic logic [3:0] ctl_reg_addr(input int m, input int k);
    return 4'(2 + 4 * m + k);
  endfunction
endpackage

// File: rtl/sqm_sts_decode.sv
`timescale 1ns/1ps
module sqm_sts_decode
  import sqm_pkg::*;
(
  input  logic             sts_valid,
  input  logic [STS_W-1:0] sts_word,
  input  logic             irq_en,
  input  logic             fifo_full,
  input  logic             pend_full,
  output logic             sts_ready,
  output logic             push,
  output logic [STS_W-1:0] push_word,
  output logic             msi_req
);
  logic take;
  assign sts_ready = !fifo_full && !pend_full;
  assign take      = sts_valid && sts_ready;
  assign push      = take && sts_keep(sts_word[CTL_LO +: 2]);
  assign push_word = sts_word;
  assign msi_req   = take && irq_en && sts_irq(sts_word[CTL_LO +: 2], sts_word[ERR_BIT]);
endmodule

// File: rtl/sqm_sts_fifo.sv
`timescale 1ns/1ps
module sqm_sts_fifo #(
  parameter int W     = 31,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end
endmodule

// File: rtl/sqm_msi_inject.sv
`timescale 1ns/1ps
module sqm_msi_inject
  import sqm_pkg::*;
#(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MOVERS-1:0] msi_req,
  input  irq_ctl_t          ctl [MOVERS],
  input  logic              norm_ready,
  input  logic              prio_ready,
  output logic              inj_valid,
  output logic              inj_to_prio,
  output logic              inj_fire,
  output logic [DESC_W-1:0] inj_desc,
  output logic [MOVERS-1:0] pend_full
);
  logic [PEND_W-1:0] cnt [MOVERS];
  logic [MOVERS-1:0] has;
  logic              sel;

  // fixed order: write mover (index 0) ahead of read mover
  assign sel         = has[0] ? 1'b0 : 1'b1;
  assign inj_valid   = |has;
  assign inj_to_prio = ctl[sel].prio;
  assign inj_desc    = msi_desc(ctl[sel].addr, ctl[sel].data);
  assign inj_fire    = inj_valid && (inj_to_prio ? prio_ready : norm_ready);

  for (genvar g = 0; g < MOVERS; g++) begin : g_pend
    logic dec;
    assign has[g]       = (cnt[g] != '0);
    assign pend_full[g] = &cnt[g];
    assign dec          = inj_fire && (sel == 1'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[g] <= '0;
      else        cnt[g] <= cnt[g] + PEND_W'(msi_req[g]) - PEND_W'(dec);
    end
  end
endmodule

// File: rtl/sqm_status_msi.sv
`timescale 1ns/1ps
module sqm_status_msi
  import sqm_pkg::*;
#(
  parameter int STS_DEPTH = 4,
  parameter int PEND_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sts_valid,
  output logic              wr_sts_ready,
  input  logic [STS_W-1:0]  wr_sts_word,
  input  logic              rd_sts_valid,
  output logic              rd_sts_ready,
  input  logic [STS_W-1:0]  rd_sts_word,
  input  logic [3:0]        csr_addr,
  input  logic              csr_write,
  input  logic              csr_read,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              host_push,
  input  logic              host_prio,
  input  logic [DESC_W-1:0] host_desc,
  output logic              host_wait,
  output logic              wq_norm_valid,
  input  logic              wq_norm_ready,
  output logic [DESC_W-1:0] wq_norm_desc,
  output logic              wq_prio_valid,
  input  logic              wq_prio_ready,
  output logic [DESC_W-1:0] wq_prio_desc
);
  logic [MOVERS-1:0] sts_valid_v, sts_ready_v, sts_push, msi_req;
  logic [MOVERS-1:0] fifo_full, fifo_empty, pend_full, sts_pop, irq_en;
  logic [STS_W-1:0]  sts_word_v [MOVERS];
  logic [STS_W-1:0]  push_word  [MOVERS];
  logic [STS_W-1:0]  head       [MOVERS];
  irq_ctl_t          ctl_q      [MOVERS];

  logic              inj_valid, inj_to_prio, inj_fire;
  logic [DESC_W-1:0] inj_desc;
  logic              msi_on_norm, msi_on_prio;

  assign sts_valid_v   = {rd_sts_valid, wr_sts_valid};
  assign sts_word_v[0] = wr_sts_word;
  assign sts_word_v[1] = rd_sts_word;
  assign wr_sts_ready  = sts_ready_v[0];
  assign rd_sts_ready  = sts_ready_v[1];

  // interrupt control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < MOVERS; m++) ctl_q[m] <= '0;
    end else if (csr_write) begin
      for (int m = 0; m < MOVERS; m++) begin
        if (csr_addr == ctl_reg_addr(m, 0)) begin
          ctl_q[m].en   <= csr_wdata[0];
          ctl_q[m].prio <= csr_wdata[1];
        end
        if (csr_addr == ctl_reg_addr(m, 1)) ctl_q[m].addr[31:0]  <= csr_wdata;
        if (csr_addr == ctl_reg_addr(m, 2)) ctl_q[m].addr[63:32] <= csr_wdata;
        if (csr_addr == ctl_reg_addr(m, 3)) ctl_q[m].data        <= csr_wdata;
      end
    end
  end

  for (genvar g = 0; g < MOVERS; g++) begin : g_mover
    assign irq_en[g]  = ctl_q[g].en;
    assign sts_pop[g] = csr_read && (csr_addr == 4'(g));

    sqm_sts_decode u_dec (
      .sts_valid (sts_valid_v[g]),
      .sts_word  (sts_word_v[g]),
      .irq_en    (irq_en[g]),
      .fifo_full (fifo_full[g]),
      .pend_full (pend_full[g]),
      .sts_ready (sts_ready_v[g]),
      .push      (sts_push[g]),
      .push_word (push_word[g]),
      .msi_req   (msi_req[g])
    );

    sqm_sts_fifo #(.W(STS_W), .DEPTH(STS_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (sts_push[g]),
      .push_data (push_word[g]),
      .pop       (sts_pop[g]),
      .head      (head[g]),
      .empty     (fifo_empty[g]),
      .full      (fifo_full[g])
    );
  end

  sqm_msi_inject #(.PEND_W(PEND_W)) u_inj (
    .clk         (clk),
    .rst_n       (rst_n),
    .msi_req     (msi_req),
    .ctl         (ctl_q),
    .norm_ready  (wq_norm_ready),
    .prio_ready  (wq_prio_ready),
    .inj_valid   (inj_valid),
    .inj_to_prio (inj_to_prio),
    .inj_fire    (inj_fire),
    .inj_desc    (inj_desc),
    .pend_full   (pend_full)
  );

  // queue arbitration: MSI ahead of host on the same queue
  assign msi_on_norm   = inj_valid && !inj_to_prio;
  assign msi_on_prio   = inj_valid && inj_to_prio;
  assign wq_norm_valid = msi_on_norm || (host_push && !host_prio);
  assign wq_prio_valid = msi_on_prio || (host_push && host_prio);
  assign wq_norm_desc  = msi_on_norm ? inj_desc : host_desc;
  assign wq_prio_desc  = msi_on_prio ? inj_desc : host_desc;
  assign host_wait     = host_push && (host_prio ? (msi_on_prio || !wq_prio_ready)
                                                 : (msi_on_norm || !wq_norm_ready));

  // register read mux
  always_comb begin
    csr_rdata = '0;
    for (int m = 0; m < MOVERS; m++) begin
      if (csr_addr == 4'(m))
        csr_rdata = fifo_empty[m] ? EMPTY_WORD : {1'b0, head[m]};
      if (csr_addr == ctl_reg_addr(m, 0)) csr_rdata = {30'b0, ctl_q[m].prio, ctl_q[m].en};
      if (csr_addr == ctl_reg_addr(m, 1)) csr_rdata = ctl_q[m].addr[31:0];
      if (csr_addr == ctl_reg_addr(m, 2)) csr_rdata = ctl_q[m].addr[63:32];
      if (csr_addr == ctl_reg_addr(m, 3)) csr_rdata = ctl_q[m].data;
    end
  end
endmodule

// File: rtl/sqm_status_msi_chk.sv
`timescale 1ns/1ps
module sqm_status_msi_chk
  import sqm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_sts_valid,
  input logic              wr_sts_ready,
  input logic [STS_W-1:0]  wr_sts_word,
  input logic [MOVERS-1:0] sts_push,
  input logic              csr_read,
  input logic [3:0]        csr_addr,
  input logic [31:0]       csr_rdata,
  input logic              host_push,
  input logic              host_prio,
  input logic              host_wait,
  input logic              inj_valid,
  input logic              inj_to_prio,
  input logic              inj_fire,
  input logic              wq_norm_valid,
  input logic [DESC_W-1:0] wq_norm_desc,
  input logic [MOVERS-1:0] msi_req,
  input logic [MOVERS-1:0] irq_en
);
  p_drop_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts_valid && wr_sts_ready && wr_sts_word[CTL_LO +: 2] == 2'b00) |-> !sts_push[0]);

  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_read && csr_addr == 4'd0 && csr_rdata[31]) |-> (csr_rdata[30:0] == '0));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req[0] |-> irq_en[0]);

  p_msi_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_to_prio) |->
      (wq_norm_valid && wq_norm_desc[F_IMM] && wq_norm_desc[F_ACTL +: 2] == 2'b00));

  p_msi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && !host_prio && inj_valid && !inj_to_prio) |-> host_wait);

  p_msi_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_fire) |=> inj_valid);
endmodule

bind sqm_status_msi sqm_status_msi_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_sts_valid  (wr_sts_valid),
  .wr_sts_ready  (wr_sts_ready),
  .wr_sts_word   (wr_sts_word),
  .sts_push      (sts_push),
  .csr_read      (csr_read),
  .csr_addr      (csr_addr),
  .csr_rdata     (csr_rdata),
  .host_push     (host_push),
  .host_prio     (host_prio),
  .host_wait     (host_wait),
  .inj_valid     (inj_valid),
  .inj_to_prio   (inj_to_prio),
  .inj_fire      (inj_fire),
  .wq_norm_valid (wq_norm_valid),
  .wq_norm_desc  (wq_norm_desc),
  .msi_req       (msi_req),
  .irq_en        (irq_en)
);

// File: tb/sqm_status_msi_bench.sv
`timescale 1ns/1ps
module sqm_status_msi_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_sts_valid = 1'b0, rd_sts_valid = 1'b0;
  logic         wr_sts_ready, rd_sts_ready;
  logic [30:0]  wr_sts_word = '0, rd_sts_word = '0;
  logic [3:0]   csr_addr = '0;
  logic         csr_write = 1'b0, csr_read = 1'b0;
  logic [31:0]  csr_wdata = '0, csr_rdata;
  logic         host_push = 1'b0, host_prio = 1'b0, host_wait;
  logic [111:0] host_desc = '0;
  logic         wq_norm_valid, wq_prio_valid;
  logic         wq_norm_ready = 1'b1, wq_prio_ready = 1'b1;
  logic [111:0] wq_norm_desc, wq_prio_desc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [111:0] exp_norm[$];
  logic [111:0] exp_prio[$];
  logic [31:0]  sts_model0[$];
  logic [31:0]  sts_model1[$];
  bit           b_en[2], b_prio[2];
  logic [63:0]  b_addr[2];
  logic [31:0]  b_data[2];

  always #10 clk = ~clk;

  sqm_status_msi u_sqm_status_msi (.*);

  task automatic chk(input bit ok, input string tag, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mkw(input logic [1:0] c, input bit err, input logic [11:0] id);
    logic [30:0] w;
    w = {15'h15A, err, 1'b0, c, id};
    return w;
  endfunction

  function automatic logic [111:0] exp_msi(input int m);
    return {2'b00, 1'b1, 13'd1, b_addr[m], b_data[m]};
  endfunction

  function automatic bit wants_irq(input logic [30:0] w);
    return (w[13:12] == 2'b11) || (w[13:12] == 2'b10 && w[15]);
  endfunction

  task automatic model_sts(input int m, input logic [30:0] w);
    if (w[13:12] != 2'b00) begin
      if (m == 0) sts_model0.push_back({1'b0, w});
      else        sts_model1.push_back({1'b0, w});
    end
    if (wants_irq(w) && b_en[m]) begin
      if (b_prio[m]) exp_prio.push_back(exp_msi(m));
      else           exp_norm.push_back(exp_msi(m));
    end
  endtask

  task automatic send_sts(input int m, input logic [30:0] w);
    model_sts(m, w);
    @(negedge clk);
    if (m == 0) begin wr_sts_valid = 1'b1; wr_sts_word = w; end
    else        begin rd_sts_valid = 1'b1; rd_sts_word = w; end
    #8;
    chk((m == 0 ? wr_sts_ready : rd_sts_ready) == 1'b1, "R9 status word accepted",
        112'(m == 0 ? wr_sts_ready : rd_sts_ready), 112'(1));
    @(posedge clk); #1;
    wr_sts_valid = 1'b0; rd_sts_valid = 1'b0;
  endtask

  task automatic send_both(input logic [30:0] w0, input logic [30:0] w1);
    model_sts(0, w0);
    model_sts(1, w1);
    @(negedge clk);
    wr_sts_valid = 1'b1; wr_sts_word = w0;
    rd_sts_valid = 1'b1; rd_sts_word = w1;
    @(posedge clk); #1;
    wr_sts_valid = 1'b0; rd_sts_valid = 1'b0;
  endtask

  task automatic csr_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_write = 1'b1;
    @(posedge clk); #1;
    csr_write = 1'b0;
  endtask

  task automatic set_ctl(input int m, input bit en, input bit pr, input logic [63:0] a, input logic [31:0] d);
    b_en[m] = en; b_prio[m] = pr; b_addr[m] = a; b_data[m] = d;
    csr_wr(4'(2 + 4 * m), {30'b0, pr, en});
    csr_wr(4'(3 + 4 * m), a[31:0]);
    csr_wr(4'(4 + 4 * m), a[63:32]);
    csr_wr(4'(5 + 4 * m), d);
  endtask

  task automatic csr_rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csr_addr = a; csr_read = 1'b1;
    #8;
    chk(csr_rdata == exp, tag, 112'(csr_rdata), 112'(exp));
    @(posedge clk); #1;
    csr_read = 1'b0;
  endtask

  task automatic rd_sts_check(input int m, input string tag);
    logic [31:0] e;
    if (m == 0) e = (sts_model0.size() == 0) ? 32'h8000_0000 : sts_model0.pop_front();
    else        e = (sts_model1.size() == 0) ? 32'h8000_0000 : sts_model1.pop_front();
    csr_rd_check(4'(m), e, tag);
  endtask

  task automatic host_send(input bit pr, input logic [111:0] d, output bit first_wait);
    if (pr) exp_prio.push_back(d); else exp_norm.push_back(d);
    @(negedge clk);
    host_push = 1'b1; host_prio = pr; host_desc = d;
    #8;
    first_wait = host_wait;
    while (host_wait) begin
      @(negedge clk); #8;
    end
    @(posedge clk); #1;
    host_push = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk); #8;
    if (rst_n && !done) begin
      if (wq_norm_valid && wq_norm_ready) begin
        if (exp_norm.size() == 0) chk(1'b0, "R5 unexpected normal-queue descriptor", wq_norm_desc, '0);
        else begin
          logic [111:0] e;
          e = exp_norm.pop_front();
          chk(wq_norm_desc == e, "R6 normal-queue descriptor", wq_norm_desc, e);
        end
      end
      if (wq_prio_valid && wq_prio_ready) begin
        if (exp_prio.size() == 0) chk(1'b0, "R5 unexpected priority-queue descriptor", wq_prio_desc, '0);
        else begin
          logic [111:0] e;
          e = exp_prio.pop_front();
          chk(wq_prio_desc == e, "R7 priority-queue descriptor", wq_prio_desc, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit w;
    for (int m = 0; m < 2; m++) begin
      b_en[m] = 0; b_prio[m] = 0; b_addr[m] = '0; b_data[m] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #8;
    chk(!wq_norm_valid && !wq_prio_valid, "R10 idle after reset",
        112'({wq_norm_valid, wq_prio_valid}), 112'(0));
    rd_sts_check(0, "R3 empty write-mover queue after reset");
    rd_sts_check(1, "R3 empty read-mover queue after reset");

    set_ctl(0, 1, 0, 64'h0000_0001_2345_6780, 32'hCAFE_0001);
    set_ctl(1, 1, 1, 64'h0000_00AB_0000_1000, 32'hBEEF_0002);
    csr_rd_check(4'd2, 32'h1, "R12 flags readback m0");
    csr_rd_check(4'd4, 32'h1, "R12 addr high readback m0");
    csr_rd_check(4'd6, 32'h3, "R12 flags readback m1");
    csr_rd_check(4'd9, 32'hBEEF_0002, "R12 data readback m1");

    // R1: drop code
    send_sts(0, mkw(2'b00, 1, 12'h007));
    idle(2);
    #8 chk(!wq_norm_valid, "R1 dropped word raises no MSI", 112'(wq_norm_valid), 112'(0));
    rd_sts_check(0, "R1 dropped word not queued");

    // R4: code patterns
    send_sts(0, mkw(2'b01, 1, 12'h011));
    send_sts(0, mkw(2'b10, 0, 12'h012));
    idle(2);
    #8 chk(!wq_norm_valid, "R4 codes 01 and 10-no-error raise no MSI", 112'(wq_norm_valid), 112'(0));
    send_sts(0, mkw(2'b10, 1, 12'h013));
    send_sts(0, mkw(2'b11, 0, 12'h014));
    idle(3);
    // R2 / R3: ordered readout, empty read leaves queue intact
    rd_sts_check(0, "R2 first kept word");
    rd_sts_check(0, "R2 second kept word");
    rd_sts_check(0, "R2 third kept word");
    rd_sts_check(0, "R2 fourth kept word");
    rd_sts_check(0, "R3 empty after drain");
    rd_sts_check(0, "R3 empty read repeated");
    send_sts(0, mkw(2'b01, 0, 12'h015));
    rd_sts_check(0, "R3 queue usable after empty reads");

    // R5: disabled
    set_ctl(0, 0, 0, 64'h0000_0001_2345_6780, 32'hCAFE_0001);
    send_sts(0, mkw(2'b11, 1, 12'h021));
    idle(3);
    #8 chk(!wq_norm_valid && !wq_prio_valid, "R5 disabled mover raises no MSI",
           112'({wq_norm_valid, wq_prio_valid}), 112'(0));
    rd_sts_check(0, "R5 word still queued when disabled");
    set_ctl(0, 1, 0, 64'h0000_0001_2345_6780, 32'hCAFE_0001);

    // R7: read mover to priority queue
    send_sts(1, mkw(2'b11, 0, 12'h031));
    idle(3);
    rd_sts_check(1, "R7 read-mover word queued");

    // R9 + R8: held MSIs and host conflict
    wq_norm_ready = 1'b0;
    send_sts(0, mkw(2'b11, 0, 12'h041));
    send_sts(0, mkw(2'b01, 0, 12'h042));
    send_sts(0, mkw(2'b11, 1, 12'h043));
    #8 chk(wq_norm_valid, "R9 MSI held while queue not ready", 112'(wq_norm_valid), 112'(1));
    fork
      host_send(0, 112'h1234_5678_9ABC_DEF0_1111, w);
      begin idle(3); wq_norm_ready = 1'b1; end
    join
    chk(w == 1'b1, "R8 host push waits behind MSI", 112'(w), 112'(1));
    rd_sts_check(0, "R9 word 1 queued during hold");
    rd_sts_check(0, "R9 word 2 queued during hold");
    rd_sts_check(0, "R9 word 3 queued during hold");

    // R10: host paths
    wq_prio_ready = 1'b0;
    fork
      host_send(1, 112'hAAAA_0000_5555, w);
      begin idle(2); wq_prio_ready = 1'b1; end
    join
    chk(w == 1'b1, "R10 host waits on not-ready queue", 112'(w), 112'(1));
    host_send(0, 112'h0F0F_F0F0, w);
    chk(w == 1'b0, "R10 host push passes at once", 112'(w), 112'(0));

    // R11: both movers same cycle, both to normal queue
    set_ctl(1, 1, 0, 64'h0000_00AB_0000_1000, 32'hBEEF_0002);
    send_both(mkw(2'b11, 0, 12'h051), mkw(2'b11, 0, 12'h052));
    idle(4);
    chk(exp_norm.size() == 0, "R11 both MSIs issued in mover order",
        112'(exp_norm.size()), 112'(0));

    idle(5);
    chk(exp_norm.size() == 0 && exp_prio.size() == 0, "R4 every expected MSI issued",
        112'(exp_norm.size() + exp_prio.size()), 112'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule